// File: doc/BRIEF.md
# DMX512 Frame Transmitter

This block sends one complete DMX512 lighting-control frame on a single serial line each time it receives a start pulse. A frame begins with a reset break and a mark-after-break. The block makes both by sending one all-zero character at a slow 100 kbaud rate, with no separate break timer. It then switches to 250 kbaud and sends a zero start code. The channel bytes follow, fetched one at a time from an external synchronous channel memory.

The number of channel slots is given for each frame on `chan_count_i` and is captured when the start is accepted. Each channel byte is read from memory while the slot before it is still being shifted out, so consecutive characters leave the line with no gap between them. `busy_o` covers the whole frame. `done_o` pulses once after the last stop bit has fully left the line. The interval between frames is set by whoever drives the start pulse.

Top module: `dmx_frame_tx`

## Requirements
- R1: While reset is held and whenever no frame is active, `tx_o` is high, `busy_o` is low and `done_o` is low.
- R2: An accepted start puts the break on the line from the following cycle. The line is low for 9 slow bit times (start bit plus 8 zero bits), then high for 2 slow bit times. One slow bit time is SLOW_DIV = CLK_HZ/BREAK_BAUD clocks.
- R3: Every character after the break is 11 fast bit times long. It is one low start bit, then 8 data bits with the least significant bit first, then two high stop bits. One fast bit time is FAST_DIV = CLK_HZ/DATA_BAUD clocks.
- R4: A start code of value 0x00 follows the break character immediately.
- R5: Channel bytes are sent in increasing address order, starting at address 0. Each read is one `rd_en_o` cycle with `rd_addr_o`, and `rd_data_i` is taken in the cycle after it. Exactly one read is made per sent channel byte.
- R6: The characters of a frame follow each other with no idle cycles between them.
- R7: `busy_o` is high from the cycle after the accepted start up to and including the last cycle of the final stop bit. In the next cycle `done_o` is high for exactly one cycle.
- R8: A start request made while `busy_o` is high is ignored. The running frame goes on unchanged.
- R9: A channel count of 0 sends only the break, the mark and the start code, and makes no memory read.
- R10: A channel count above MAX_SLOTS (512) is treated as MAX_SLOTS.
- R11: The channel count is sampled only when a start is accepted. Changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one frame; accepted only when idle |
| chan_count_i | input | CNT_W (10) | Channel slots for the next frame |
| rd_en_o | output | 1 | Channel memory read strobe |
| rd_addr_o | output | ADDR_W (9) | Channel memory read address |
| rd_data_i | input | 8 | Channel memory data, valid one cycle after the read strobe |
| tx_o | output | 1 | Serial line output, idle high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse once a frame has fully left the line |

## Verification
The assertions assume a channel memory that always returns data one cycle after a read strobe. They also assume that a character lasts far longer than that read latency, which holds whenever both bit times are at least a few clocks. The bench models the memory with exactly that one-cycle latency. It scales the clock so that the slow and fast bit times are 10 and 4 clocks, which keeps the 5:2 baud ratio of the real rates while keeping frames short. Start pulses and count changes made during a frame are driven only from the bench's own idle/busy model. This lets the ignored-start and sampled-count cases be checked without ambiguity.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BREAK = 2'd1,
    PH_SCODE = 2'd2,
    PH_DATA  = 2'd3
  } phase_t;

  // clocks per bit for a given baud rate
  function automatic int bit_div(input int clk_hz, input int baud);
    return clk_hz / baud;
  endfunction

  // character on the wire, LSB first: start(0), 8 data, 2 stop(1)
  function automatic logic [10:0] char_bits(input logic [7:0] b);
    return {2'b11, b, 1'b0};
  endfunction

  // limit requested slot count to the frame maximum
  function automatic int clamp_slots(input int req, input int max_slots);
    return (req > max_slots) ? max_slots : req;
  endfunction

endpackage

// File: rtl/dmx_bit_timer.sv
module dmx_bit_timer #(
  parameter int SLOW_DIV = 320,
  parameter int FAST_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slow_sel,
  input  logic run,
  output logic bit_end
);
  localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DIV_W  = $clog2(MAXDIV + 1);
  localparam logic [DIV_W-1:0] SLOW_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [DIV_W-1:0] FAST_LAST = DIV_W'(FAST_DIV - 1);

  logic [DIV_W-1:0] cnt_q;
  logic             slow_q;

  assign bit_end = run && (cnt_q == (slow_q ? SLOW_LAST : FAST_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      slow_q <= slow_sel;
    end else if (run) begin
      cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dmx_char_shifter.sv
module dmx_char_shifter #(
  parameter int SLOW_DIV = 320,
  parameter int FAST_DIV = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       load_slow,
  output logic       char_done,
  output logic       tx_o
);
  import dmx_tx_pkg::*;

  logic [10:0] sh_q;
  logic [3:0]  bitn_q;
  logic        active_q;
  logic        bit_end;

  dmx_bit_timer #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .slow_sel(load_slow),
    .run     (active_q),
    .bit_end (bit_end)
  );

  assign char_done = bit_end && (bitn_q == 4'd10);
  assign tx_o      = sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '1;
      bitn_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      sh_q     <= char_bits(load_byte);
      bitn_q   <= '0;
      active_q <= 1'b1;
    end else if (bit_end) begin
      sh_q   <= {1'b1, sh_q[10:1]};
      bitn_q <= bitn_q + 1'b1;
      if (bitn_q == 4'd10) active_q <= 1'b0;
    end
  end

  // R3: every character opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx_o);
  // R3: both stop bits drive the line high
  a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && bitn_q >= 4'd9) |-> tx_o);

endmodule

// File: rtl/dmx_frame_seq.sv
module dmx_frame_seq #(
  parameter int MAX_SLOTS = 512,
  parameter int CNT_W     = 10,
  parameter int ADDR_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  chan_count_i,
  input  logic              char_done,
  input  logic [7:0]        rd_data_i,
  output logic              load,
  output logic [7:0]        load_byte,
  output logic              load_slow,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  import dmx_tx_pkg::*;

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_SLOTS);

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, sent_q, rdn_q;
  logic [7:0]       byte_q;
  logic             rd_pend_q, done_q, fin, more, data_load;

  assign more = sent_q < cnt_q;

  always_comb begin
    ph_d      = ph_q;
    load      = 1'b0;
    load_byte = 8'h00;
    load_slow = 1'b0;
    fin       = 1'b0;
    data_load = 1'b0;
    case (ph_q)
      PH_IDLE: if (start_i) begin
        load      = 1'b1;
        load_slow = 1'b1;
        ph_d      = PH_BREAK;
      end
      PH_BREAK: if (char_done) begin
        load = 1'b1;
        ph_d = PH_SCODE;
      end
      default: if (char_done) begin
        if (more) begin
          load      = 1'b1;
          load_byte = byte_q;
          data_load = 1'b1;
          ph_d      = PH_DATA;
        end else begin
          fin  = 1'b1;
          ph_d = PH_IDLE;
        end
      end
    endcase
  end

  // prefetch the following slot while the current one shifts out
  assign rd_en_o   = load && !load_slow && (rdn_q < cnt_q);
  assign rd_addr_o = rdn_q[ADDR_W-1:0];
  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      sent_q    <= '0;
      rdn_q     <= '0;
      byte_q    <= '0;
      rd_pend_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      done_q    <= fin;
      rd_pend_q <= rd_en_o;
      if (rd_pend_q) byte_q <= rd_data_i;
      if (ph_q == PH_IDLE && start_i) begin
        cnt_q  <= CNT_W'(clamp_slots(int'(chan_count_i), MAX_SLOTS));
        sent_q <= '0;
        rdn_q  <= '0;
      end else begin
        if (rd_en_o)   rdn_q  <= rdn_q + 1'b1;
        if (data_load) sent_q <= sent_q + 1'b1;
      end
    end
  end

  // R10: latched count never exceeds the frame maximum
  a_r10_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_CNT);
  // R8, R11: a start while busy leaves the latched count alone
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(cnt_q));
  // R7: frame-done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: at most one read per slot, never in consecutive cycles
  a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);

endmodule

// File: rtl/dmx_frame_tx.sv
module dmx_frame_tx #(
  parameter int CLK_HZ     = 32_000_000,
  parameter int BREAK_BAUD = 100_000,
  parameter int DATA_BAUD  = 250_000,
  parameter int MAX_SLOTS  = 512,
  parameter int CNT_W      = $clog2(MAX_SLOTS + 1),
  parameter int ADDR_W     = $clog2(MAX_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  chan_count_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              tx_o,
  output logic              busy_o,
  output logic              done_o
);
  import dmx_tx_pkg::*;

  localparam int SLOW_DIV = bit_div(CLK_HZ, BREAK_BAUD);
  localparam int FAST_DIV = bit_div(CLK_HZ, DATA_BAUD);

  logic       load, load_slow, char_done;
  logic [7:0] load_byte;

  dmx_frame_seq #(.MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .chan_count_i(chan_count_i),
    .char_done   (char_done),
    .rd_data_i   (rd_data_i),
    .load        (load),
    .load_byte   (load_byte),
    .load_slow   (load_slow),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  dmx_char_shifter #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_byte(load_byte),
    .load_slow(load_slow),
    .char_done(char_done),
    .tx_o     (tx_o)
  );

  // R1: the line rests at mark whenever no frame is running
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);

endmodule

// File: tb/sim_dmx_frame_tx.sv
module sim_dmx_frame_tx;
  localparam int CLK_HZ = 1000;
  localparam int SD     = 1000 / 100;  // slow bit time in clocks
  localparam int FD     = 1000 / 250;  // fast bit time in clocks
  localparam int MAXS   = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] chan_count = '0;
  logic       rd_en, tx, busy, done;
  logic [8:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic [7:0] mem [MAXS];

  always #10 clk = ~clk;

  dmx_frame_tx #(.CLK_HZ(CLK_HZ), .BREAK_BAUD(100), .DATA_BAUD(250)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chan_count_i(chan_count),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .tx_o(tx), .busy_o(busy), .done_o(done));

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  typedef struct { logic b; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0, cyc = 0;
  int reads = 0, rd_expect = 0, busy_cnt = 0;
  bit popped = 0, prev_popped = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push_char(input logic [7:0] b, input int div, input string tag);
    logic [10:0] bits;
    bits = {2'b11, b, 1'b0};
    for (int i = 0; i < 11; i++)
      for (int k = 0; k < div; k++) q.push_back('{bits[i], tag});
  endtask

  function automatic int clampn(input int n);
    return (n > MAXS) ? MAXS : n;
  endfunction

  task automatic push_frame(input int n);
    push_char(8'h00, SD, "R2");
    push_char(8'h00, FD, "R4");
    for (int i = 0; i < clampn(n); i++)
      push_char(mem[i], FD, (i == 0) ? "R3" : "R6");
    reads = 0; rd_expect = 0; busy_cnt = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic tick();
    exp_t e;
    bit exp_tx, exp_done;
    string tg;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      check(0, "R7", "watchdog expired", cyc, 150000);
      finish_run();
    end
    if (q.size() > 0) begin
      e = q.pop_front(); exp_tx = e.b; tg = e.tag; popped = 1;
    end else begin
      exp_tx = 1'b1; tg = "R1"; popped = 0;
    end
    exp_done = prev_popped && !popped;
    prev_popped = popped;
    check(tx === exp_tx, tg, "tx line", int'(tx), int'(exp_tx));
    check(busy === popped, "R7", "busy", int'(busy), int'(popped));
    check(done === exp_done, "R7", "done pulse", int'(done), int'(exp_done));
    if (rd_en === 1'b1) begin
      check(int'(rd_addr) == rd_expect, "R5", "read address", int'(rd_addr), rd_expect);
      rd_expect++; reads++;
    end
    if (busy === 1'b1) busy_cnt++;
  endtask

  task automatic begin_frame(input int n);
    chan_count = 10'(n);
    start = 1'b1;
    if (!popped) push_frame(n);
    tick();
    start = 1'b0;
  endtask

  // run until the frame is over; optional stray start (R8) and count change (R11)
  task automatic wait_frame(input int n, input bit stray, input string tag);
    int k = 0;
    while (popped) begin
      if (stray && k == 20) chan_count = 10'd2;
      if (stray && (k == 60 || k == 200)) start = 1'b1;
      tick();
      start = 1'b0;
      k++;
    end
    check(reads == clampn(n), tag, "channel reads in frame", reads, clampn(n));
    check(busy_cnt == 11 * SD + 11 * FD * (1 + clampn(n)), tag, "busy length",
          busy_cnt, 11 * SD + 11 * FD * (1 + clampn(n)));
  endtask

  initial begin
    for (int i = 0; i < MAXS; i++) mem[i] = 8'((i * 37 + 11) & 255);
    // R1: reset state, start held during reset has no effect
    start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tx === 1'b1, "R1", "tx in reset", int'(tx), 1);
      check(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
      check(done === 1'b0, "R1", "done in reset", int'(done), 0);
    end
    start = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    begin_frame(3);   wait_frame(3, 0, "R5");
    begin_frame(0);   wait_frame(0, 0, "R9");
    begin_frame(1);   wait_frame(1, 0, "R6");
    for (int i = 0; i < 7; i++) tick();
    begin_frame(5);   wait_frame(5, 1, "R11");
    check(busy_cnt == 11 * SD + 11 * FD * 6, "R8", "frame length with stray starts",
          busy_cnt, 11 * SD + 11 * FD * 6);
    for (int i = 0; i < MAXS; i++) mem[i] = 8'(i) ^ 8'hA5;
    begin_frame(600); wait_frame(600, 0, "R10");
    for (int i = 0; i < 10; i++) tick();
    finish_run();
  end
endmodule